// File: doc/BRIEF.md
# Dual-Counter PWM Timer

This block generates a single pulse-width-modulated output from two identical reloadable counters. Counter 0 measures out the period and counter 1 measures out the high time inside that period. Each counter has a control word, a load word and a live count word. A plain write/read register port with 32-bit words at a 4-byte stride reaches all six words. The counter width `W` is a parameter and may be 8, 16 or 32.

Software first puts both counters into the load state so their count registers take the load values. It then sets the PWM configuration and writes the start-both bit once, so both counters begin counting on the same clock edge. While the PWM runs, a load value written by software only takes effect at the next period boundary. At every period boundary counter 1 is restarted together with counter 0, which keeps the high time phase-locked to the period.

Top module: `dual_timer_pwm`

## Requirements
- R1: After reset every register reads zero and `pwm_o` is low.
- R2: Word offsets are 0x00 control 0, 0x04 load 0, 0x08 count 0, 0x10 control 1, 0x14 load 1, 0x18 count 1; other offsets read zero. Control bits: 0 count-down, 1 generate mode, 2 auto-reload, 3 load, 4 output enable, 5 run enable, 6 PWM mode. Bit 7 (start-both) and bit 8 (cascade) always read zero. Load words keep only their low `W` bits. Writes to the count words are ignored.
- R3: While the load bit is set, the count word equals the load word and does not advance, even with run enable set.
- R4: With count-down set and auto-reload set, the count steps L, L-1, ..., 0, then 2^W-1 for one cycle, then L again, giving a cycle of L+2 clocks.
- R5: With count-down clear and auto-reload set, the count steps L, ..., 2^W-1, then 0 for one cycle, then L again, giving a cycle of (2^W-1)-L+2 clocks.
- R6: Writing a control word with bit 7 set also sets the run enable of the other control word on the same edge.
- R7: PWM is active only when both control words have run enable, auto-reload, output enable, PWM mode and generate mode set and the load bit clear. When PWM is not active, `pwm_o` is low from the following cycle on.
- R8: Once PWM becomes active, `pwm_o` is high from the second edge after activation. Each period lasts len0 clocks, and within it `pwm_o` is high for the first len1 clocks. len0 and len1 are the R4/R5 cycle lengths of counters 0 and 1.
- R9: If len1 is greater than or equal to len0, `pwm_o` stays low.
- R10: A load 1 write while PWM runs leaves the current high time unchanged and sets the high time of the next period.
- R11: With auto-reload clear, a running counter stops at its terminal value (0 when counting down, 2^W-1 when counting up).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Byte address of the word written |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Byte address of the word read |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| pwm_o | output | 1 | PWM output |

## Verification
The bench builds the block with `W` = 8. With that width, up-counting periods of the form (2^W-1)-L+2 stay a few clocks long, and the wrap through 2^W-1 and 0 appears within a handful of cycles. The same setting lets load-word truncation show up on readback. The vector table mixes up and down directions on each counter and includes the shortest period, equal lengths and a high time longer than the period. The directed tests cover mid-run reloads and deactivation.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;

  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 32;
  localparam int CTL_W    = 7;
  localparam int BOTH_BIT = 7;

  // Control word, bit 0 at the right.
  typedef struct packed {
    logic pwm;   // bit 6
    logic en;    // bit 5
    logic oe;    // bit 4
    logic ld;    // bit 3
    logic rld;   // bit 2
    logic gen;   // bit 1
    logic dn;    // bit 0
  } ctl_t;

  function automatic logic pwm_ready(input ctl_t c);
    return c.en & c.rld & c.oe & c.pwm & c.gen & ~c.ld;
  endfunction

endpackage

// File: rtl/tpwm_regs.sv
module tpwm_regs
  import tpwm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [DATA_W-1:0]     rd_data,
  input  logic [1:0][W-1:0]     cnt_i,
  output ctl_t [1:0]            ctl_o,
  output logic [1:0][W-1:0]     load_o
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wr_word;
  logic [WORD_W-1:0] rd_word;
  logic [1:0]        sel_ctl;
  logic [1:0]        sel_load;
  logic              both_wr;

  assign wr_word = wr_addr[ADDR_W-1:2];
  assign rd_word = rd_addr[ADDR_W-1:2];
  assign both_wr = (|sel_ctl) & wr_data[BOTH_BIT];

  logic unused_bits;
  assign unused_bits = ^{wr_addr[1:0], rd_addr[1:0], wr_data[DATA_W-1:BOTH_BIT+1]};

  for (genvar t = 0; t < 2; t++) begin : g_tmr
    ctl_t           ctl_q, ctl_d;
    logic           ctl_ce;
    logic [W-1:0]   load_q, load_d;
    logic           load_ce;

    assign sel_ctl[t]  = wr_en & (wr_word == WORD_W'(t * 4));
    assign sel_load[t] = wr_en & (wr_word == WORD_W'(t * 4 + 1));

    always_comb begin
      ctl_ce = sel_ctl[t] | both_wr;
      ctl_d  = ctl_q;
      if (sel_ctl[t]) ctl_d = ctl_t'(wr_data[CTL_W-1:0]);
      if (both_wr)    ctl_d.en = 1'b1;
      load_ce = sel_load[t];
      load_d  = wr_data[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_q  <= '0;
        load_q <= '0;
      end else begin
        if (ctl_ce)  ctl_q  <= ctl_d;
        if (load_ce) load_q <= load_d;
      end
    end

    assign ctl_o[t]  = ctl_q;
    assign load_o[t] = load_q;
  end

  always_comb begin
    case (rd_word)
      WORD_W'(0): rd_data = DATA_W'(ctl_o[0]);
      WORD_W'(1): rd_data = DATA_W'(load_o[0]);
      WORD_W'(2): rd_data = DATA_W'(cnt_i[0]);
      WORD_W'(4): rd_data = DATA_W'(ctl_o[1]);
      WORD_W'(5): rd_data = DATA_W'(load_o[1]);
      WORD_W'(6): rd_data = DATA_W'(cnt_i[1]);
      default:    rd_data = '0;
    endcase
  end

  // R6: start-both reaches both run enables on the same edge
  a_r6_both_start: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[BOTH_BIT] && (wr_word == WORD_W'(0) || wr_word == WORD_W'(4)))
      |=> (ctl_o[0].en && ctl_o[1].en));

  // R2: a load word changes only through its own write strobe
  a_r2_load_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_load[0] |=> $stable(load_o[0]));

endmodule

// File: rtl/tpwm_counter.sv
module tpwm_counter
  import tpwm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ctl_t         ctl_i,
  input  logic [W-1:0] load_i,
  input  logic         restart_i,
  output logic [W-1:0] count_o,
  output logic         reload_cyc_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         fl_q, fl_d;
  logic         term;
  logic         cnt_ce;

  assign term = ctl_i.dn ? (cnt_q == '0) : (cnt_q == '1);

  always_comb begin
    cnt_d  = cnt_q;
    fl_d   = fl_q;
    cnt_ce = 1'b0;
    if (ctl_i.ld || restart_i) begin
      cnt_ce = 1'b1;
      cnt_d  = load_i;
      fl_d   = 1'b0;
    end else if (ctl_i.en) begin
      if (fl_q) begin
        cnt_ce = 1'b1;
        cnt_d  = load_i;
        fl_d   = 1'b0;
      end else if (!term || ctl_i.rld) begin
        cnt_ce = 1'b1;
        cnt_d  = ctl_i.dn ? cnt_q - 1'b1 : cnt_q + 1'b1;
        fl_d   = term;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fl_q  <= 1'b0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
      fl_q  <= fl_d;
    end
  end

  assign count_o      = cnt_q;
  assign reload_cyc_o = fl_q;

  // R3: the load bit copies the load word and stalls counting
  a_r3_load_stall: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_i.ld |=> (count_o == $past(load_i)));

  // R4 / R5: the cycle after the wrap takes the load value again
  a_r4_reload_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_cyc_o && ctl_i.en && !ctl_i.ld) |=> (count_o == $past(load_i)));

  // R11: without auto-reload a counter at its end value stays there
  a_r11_hold_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_i.en && !ctl_i.ld && !ctl_i.rld && !restart_i && !reload_cyc_o &&
     (ctl_i.dn ? (count_o == '0) : (count_o == '1))) |=> $stable(count_o));

endmodule

// File: rtl/tpwm_wave.sv
module tpwm_wave
  import tpwm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ctl_t         ctl0_i,
  input  ctl_t         ctl1_i,
  input  logic [W-1:0] load0_i,
  input  logic [W-1:0] load1_i,
  input  logic         end0_i,
  input  logic         end1_i,
  output logic         restart_o,
  output logic         pwm_o
);

  localparam int LW = W + 2;

  function automatic logic [LW-1:0] cyc_len(input logic dn, input logic [W-1:0] l);
    logic [LW-1:0] top;
    top = LW'({W{1'b1}});
    return dn ? (LW'(l) + LW'(2)) : (top - LW'(l) + LW'(2));
  endfunction

  logic          active;
  logic          act_q;
  logic          q_q, q_d;
  logic [LW-1:0] len0, len1;

  assign active    = pwm_ready(ctl0_i) & pwm_ready(ctl1_i);
  assign len0      = cyc_len(ctl0_i.dn, load0_i);
  assign len1      = cyc_len(ctl1_i.dn, load1_i);
  assign restart_o = active & (end0_i | ~act_q);

  always_comb begin
    q_d = q_q;
    if (!active)        q_d = 1'b0;
    else if (restart_o) q_d = (len1 < len0);
    else if (end1_i)    q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      q_q   <= 1'b0;
    end else begin
      act_q <= active;
      q_q   <= q_d;
    end
  end

  assign pwm_o = q_q;

  // R7: inactive configuration drives the output low next cycle
  a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !pwm_o);

  // R8: the output only rises from a period start
  a_r8_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_o) |-> $past(restart_o));

  // R9: a high time not shorter than the period yields no pulse
  a_r9_long_high_low: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_o && (len1 >= len0)) |=> !pwm_o);

endmodule

// File: rtl/dual_timer_pwm.sv
module dual_timer_pwm
  import tpwm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [4:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        pwm_o
);

  logic [1:0] rs_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  ctl_t [1:0]         ctl;
  logic [1:0][W-1:0]  load;
  logic [1:0][W-1:0]  cnt;
  logic [1:0]         end_cyc;
  logic               restart;

  tpwm_regs #(.W(W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .cnt_i   (cnt),
    .ctl_o   (ctl),
    .load_o  (load)
  );

  for (genvar t = 0; t < 2; t++) begin : g_cnt
    tpwm_counter #(.W(W)) u_cnt (
      .clk          (clk),
      .rst_n        (rst_n_s),
      .ctl_i        (ctl[t]),
      .load_i       (load[t]),
      .restart_i    (restart),
      .count_o      (cnt[t]),
      .reload_cyc_o (end_cyc[t])
    );
  end

  tpwm_wave #(.W(W)) u_wave (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .ctl0_i    (ctl[0]),
    .ctl1_i    (ctl[1]),
    .load0_i   (load[0]),
    .load1_i   (load[1]),
    .end0_i    (end_cyc[0]),
    .end1_i    (end_cyc[1]),
    .restart_o (restart),
    .pwm_o     (pwm_o)
  );

endmodule

// File: tb/dual_timer_pwm_test.sv
`timescale 1ns/1ps
module dual_timer_pwm_test;

  localparam int W = 8;
  localparam int C_DN = 1, C_GEN = 2, C_RLD = 4, C_LD = 8, C_OE = 16,
                 C_EN = 32, C_PWM = 64, C_BOTH = 128;
  localparam int CFG = C_GEN | C_RLD | C_OE | C_PWM;

  // {dn0, load0, dn1, load1}
  localparam logic [17:0] VEC [6] = '{
    {1'b1, 8'd8,   1'b1, 8'd3},
    {1'b0, 8'd250, 1'b1, 8'd1},
    {1'b1, 8'd4,   1'b1, 8'd4},
    {1'b1, 8'd3,   1'b0, 8'd253},
    {1'b1, 8'd2,   1'b1, 8'd9},
    {1'b1, 8'd1,   1'b1, 8'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        pwm_o;

  int n_chk = 0;
  int n_bad = 0;

  dual_timer_pwm #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_o(pwm_o)
  );

  always #4 clk = ~clk;

  function automatic int blen(input bit dn, input int l);
    return dn ? l + 2 : 255 - l + 2;
  endfunction

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d (0x%0h), expected %0d (0x%0h)", rq, act, act, exp, exp);
    end
  endtask

  // called at a negedge, returns at the following negedge
  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 32'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = 5'(a);
    #1;
    v = int'(rd_data);
  endtask

  task automatic skip(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_pwm(input bit dn0, input int l0, input bit dn1, input int l1);
    wr(32'h00, 0); wr(32'h10, 0);
    wr(32'h04, l0); wr(32'h14, l1);
    wr(32'h00, C_LD | int'(dn0)); wr(32'h10, C_LD | int'(dn1));
    wr(32'h00, CFG | int'(dn0));
    wr(32'h10, CFG | C_BOTH | int'(dn1));
  endtask

  initial begin
    int v, hi, rises, len0, len1, guard;
    bit prev;
    skip(3);
    rst_n = 1'b1;
    skip(4);

    // R1: reset state
    chk("R1 pwm_o", int'(pwm_o), 0);
    for (int a = 0; a < 32; a += 4) begin
      rd(a, v);
      chk("R1 register", v, 0);
    end

    // R2 / R6 / R3: readback, masking, ignored count write, stall
    wr(32'h00, 32'h1FF);
    rd(32'h00, v); chk("R2 control readback", v, 32'h7F);
    rd(32'h10, v); chk("R6 other run enable", v, C_EN);
    wr(32'h04, 32'hFFFFFF12);
    wr(32'h08, 32'h55);
    rd(32'h04, v); chk("R2 load truncation", v, 32'h12);
    rd(32'h08, v); chk("R2 count write ignored", v, 32'h12);
    skip(4);
    rd(32'h08, v); chk("R3 stalled while load", v, 32'h12);
    rd(32'h0C, v); chk("R2 unmapped word", v, 0);
    wr(32'h00, 0); wr(32'h10, 0);

    // R4: down count with wrap
    wr(32'h04, 5); wr(32'h00, C_LD | C_DN); wr(32'h00, C_DN | C_RLD | C_EN);
    rd(32'h08, v); chk("R4 start", v, 5);
    skip(6); rd(32'h08, v); chk("R4 wrap value", v, 255);
    skip(1); rd(32'h08, v); chk("R4 reload after L+2", v, 5);

    // R5: up count with wrap
    wr(32'h04, 250); wr(32'h00, C_LD); wr(32'h00, C_RLD | C_EN);
    rd(32'h08, v); chk("R5 start", v, 250);
    skip(5); rd(32'h08, v); chk("R5 top", v, 255);
    skip(1); rd(32'h08, v); chk("R5 wrap value", v, 0);
    skip(1); rd(32'h08, v); chk("R5 reload after max-L+2", v, 250);

    // R11: no auto-reload holds at end value
    wr(32'h04, 3); wr(32'h00, C_LD | C_DN); wr(32'h00, C_DN | C_EN);
    skip(3); rd(32'h08, v); chk("R11 reached zero", v, 0);
    skip(5); rd(32'h08, v); chk("R11 held at zero", v, 0);

    // R8 / R9: vector table
    foreach (VEC[i]) begin
      len0 = blen(VEC[i][17], int'(VEC[i][16:9]));
      len1 = blen(VEC[i][8], int'(VEC[i][7:0]));
      start_pwm(VEC[i][17], int'(VEC[i][16:9]), VEC[i][8], int'(VEC[i][7:0]));
      skip(1);
      hi = 0; rises = 0; prev = 1'b0;
      for (int c = 0; c < 3 * len0; c++) begin
        if (pwm_o) hi++;
        if (pwm_o && !prev) rises++;
        prev = pwm_o;
        @(negedge clk);
      end
      if (len1 < len0) begin
        chk("R8 high clocks over 3 periods", hi, 3 * len1);
        chk("R8 pulses over 3 periods", rises, 3);
      end else begin
        chk("R9 high clocks (len1>=len0)", hi, 0);
        chk("R9 pulses (len1>=len0)", rises, 0);
      end
    end

    // R10: load 1 rewritten while running
    start_pwm(1'b1, 8, 1'b1, 3);
    guard = 0;
    while (!pwm_o && guard < 40) begin @(negedge clk); guard++; end
    hi = 1;
    wr(32'h14, 6);
    while (pwm_o && guard < 80) begin hi++; @(negedge clk); guard++; end
    chk("R10 current high unchanged", hi, 5);
    while (!pwm_o && guard < 120) begin @(negedge clk); guard++; end
    hi = 0;
    while (pwm_o && guard < 160) begin hi++; @(negedge clk); guard++; end
    chk("R10 next high uses new load", hi, 8);

    // R7: clearing output enable stops the output
    wr(32'h10, C_GEN | C_RLD | C_PWM | C_EN);
    skip(1);
    hi = 0;
    for (int c = 0; c < 24; c++) begin
      if (pwm_o) hi++;
      @(negedge clk);
    end
    chk("R7 low without output enable", hi, 0);

    // R7: generate mode cleared on timer 0
    start_pwm(1'b1, 8, 1'b1, 3);
    wr(32'h00, C_RLD | C_OE | C_PWM | C_EN | C_DN);
    skip(1);
    hi = 0;
    for (int c = 0; c < 24; c++) begin
      if (pwm_o) hi++;
      @(negedge clk);
    end
    chk("R7 low without generate mode", hi, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule